// File: doc/BRIEF.md
# Fixed-Priority Multi-Requester APB Joiner

This block lets many APB requesters share one APB completer. While idle it sits in an evaluation phase, shown on the `eval_phase` output. In that phase it looks at every requester's select line and picks the lowest-numbered one that is asserting it. The choice is stored in a grant register. From the next cycle the winner's select, write flag, address and write data are steered to the completer.

The completer always gets a proper APB setup cycle with its enable low, followed by access cycles. The winner's enable line is forwarded once the access phase begins. The completer's ready and read data go back only to the winner. Every other requester sees ready and read data held at zero, so each waits in its own access phase until it is granted. The grant stays locked until the completer signals ready in the access phase. On the next cycle the block is back in evaluation.

Top module: `apb_prio_xbar`

## Requirements
- R1: While reset is high and on the first cycle after it, `eval_phase` is 1, `cmp_psel` and `cmp_penable` are 0, and every bit of `req_pready` is 0.
- R2: In the evaluation phase, when one or more bits of `req_psel` are 1, the grant goes to the lowest index among them. Index 0 has the highest priority.
- R3: `eval_phase` is 1 exactly when no grant is held. It stays 1 for as long as no `req_psel` bit is set.
- R4: The cycle after a grant decision is a setup cycle. In it, `cmp_psel` equals the winner's select and `cmp_penable` is 0. In every following cycle of the grant, `cmp_penable` equals the winner's enable.
- R5: While a grant is held, `cmp_pwrite`, `cmp_paddr` and `cmp_pwdata` equal the winner's write flag, address and write data.
- R6: `req_pready` and `req_prdata` for the winner carry `cmp_pready` and `cmp_prdata` only in the access phase. All other requesters, and the winner in other cycles, get 0 on both.
- R7: A held grant does not change until `cmp_pready` is 1 in the access phase. This holds even if higher-priority requesters raise select in the meantime.
- R8: After a cycle in which `cmp_pready` is 1 in the access phase, the next cycle is an evaluation cycle.
- R9: In the evaluation phase, `cmp_psel` and `cmp_penable` are 0.
- R10: `cmp_pready` during the setup cycle is ignored. No requester gets ready, and the grant moves on to the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_psel | input | NREQ | Select line, one bit per requester |
| req_penable | input | NREQ | Enable line, one bit per requester |
| req_pwrite | input | NREQ | Write flag, one bit per requester |
| req_paddr | input | NREQ*AW | Address per requester; requester i occupies bits [i*AW +: AW] |
| req_pwdata | input | NREQ*DW | Write data per requester; requester i occupies bits [i*DW +: DW] |
| req_pready | output | NREQ | Ready returned to each requester |
| req_prdata | output | NREQ*DW | Read data returned to each requester; requester i occupies bits [i*DW +: DW] |
| cmp_psel | output | 1 | Select to the completer |
| cmp_penable | output | 1 | Enable to the completer |
| cmp_pwrite | output | 1 | Write flag to the completer |
| cmp_paddr | output | AW | Address to the completer |
| cmp_pwdata | output | DW | Write data to the completer |
| cmp_pready | input | 1 | Ready from the completer |
| cmp_prdata | input | DW | Read data from the completer |
| eval_phase | output | 1 | High while the block is free to take a new grant decision |

## Verification
Some properties are checked on every cycle. The completer select is quiet while evaluating. Enable never appears without select from the previous cycle. At most one requester sees ready, and only when the completer is in an enabled, ready access. A finished transfer is always followed by evaluation. Which requester wins, whether its address and data are forwarded unchanged, and whether the grant survives higher-priority requests and a ready during setup can only be shown by the bench's scenarios. The bench runs a cycle-level model of the grant against simultaneous and back-to-back requests.

// File: rtl/apbx_pkg.sv
package apbx_pkg;
  typedef enum logic [1:0] {
    PH_EVAL   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;
endpackage

// File: rtl/apbx_prio_pick.sv
module apbx_prio_pick #(
  parameter int NREQ = 32,
  localparam int GW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0] req,
  output logic            any,
  output logic [GW-1:0]   idx
);
  always_comb begin
    idx = '0;
    // scan downward so the lowest set index is the one left standing
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) idx = GW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/apbx_grant_fsm.sv
module apbx_grant_fsm
  import apbx_pkg::*;
#(
  parameter int NREQ = 32,
  localparam int GW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_req,
  input  logic [GW-1:0] pick,
  input  logic          done,
  output phase_t        phase,
  output logic [GW-1:0] gnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_EVAL;
      gnt   <= '0;
    end else begin
      unique case (phase)
        PH_EVAL: if (any_req) begin
          phase <= PH_SETUP;
          gnt   <= pick;
        end
        PH_SETUP:  phase <= PH_ACCESS;
        PH_ACCESS: if (done) phase <= PH_EVAL;
        default:   phase <= PH_EVAL;
      endcase
    end
  end
endmodule

// File: rtl/apbx_resp_route.sv
module apbx_resp_route #(
  parameter int NREQ = 32,
  parameter int DW   = 32,
  localparam int GW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic               access,
  input  logic [GW-1:0]      gnt,
  input  logic               cmp_pready,
  input  logic [DW-1:0]      cmp_prdata,
  output logic [NREQ-1:0]    req_pready,
  output logic [NREQ*DW-1:0] req_prdata
);
  for (genvar i = 0; i < NREQ; i++) begin : g_port
    logic hit;
    assign hit = access && (gnt == GW'(i));
    assign req_pready[i]            = hit ? cmp_pready : 1'b0;
    assign req_prdata[i*DW +: DW]   = hit ? cmp_prdata : '0;
  end
endmodule

// File: rtl/apb_prio_xbar.sv
module apb_prio_xbar
  import apbx_pkg::*;
#(
  parameter int NREQ = 32,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREQ-1:0]    req_psel,
  input  logic [NREQ-1:0]    req_penable,
  input  logic [NREQ-1:0]    req_pwrite,
  input  logic [NREQ*AW-1:0] req_paddr,
  input  logic [NREQ*DW-1:0] req_pwdata,
  output logic [NREQ-1:0]    req_pready,
  output logic [NREQ*DW-1:0] req_prdata,
  output logic               cmp_psel,
  output logic               cmp_penable,
  output logic               cmp_pwrite,
  output logic [AW-1:0]      cmp_paddr,
  output logic [DW-1:0]      cmp_pwdata,
  input  logic               cmp_pready,
  input  logic [DW-1:0]      cmp_prdata,
  output logic               eval_phase
);
  localparam int GW = (NREQ > 1) ? $clog2(NREQ) : 1;

  phase_t        phase;
  logic [GW-1:0] gnt;
  logic [GW-1:0] pick;
  logic          any_req;
  logic          access;
  logic          held;

  apbx_prio_pick #(.NREQ(NREQ)) u_pick (
    .req (req_psel),
    .any (any_req),
    .idx (pick)
  );

  apbx_grant_fsm #(.NREQ(NREQ)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .any_req (any_req),
    .pick    (pick),
    .done    (cmp_pready),
    .phase   (phase),
    .gnt     (gnt)
  );

  assign access     = (phase == PH_ACCESS);
  assign held       = (phase != PH_EVAL);
  assign eval_phase = (phase == PH_EVAL);

  // request path: steer the winner's lines, quiet everything while evaluating
  always_comb begin
    cmp_psel    = held   && req_psel[gnt];
    cmp_penable = access && req_penable[gnt];
    cmp_pwrite  = held   && req_pwrite[gnt];
    cmp_paddr   = held ? req_paddr[gnt*AW +: AW]  : '0;
    cmp_pwdata  = held ? req_pwdata[gnt*DW +: DW] : '0;
  end

  apbx_resp_route #(.NREQ(NREQ), .DW(DW)) u_resp (
    .access     (access),
    .gnt        (gnt),
    .cmp_pready (cmp_pready),
    .cmp_prdata (cmp_prdata),
    .req_pready (req_pready),
    .req_prdata (req_prdata)
  );
endmodule

// File: rtl/apbx_checker.sv
module apbx_checker #(
  parameter int NREQ = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            eval_phase,
  input logic            cmp_psel,
  input logic            cmp_penable,
  input logic            cmp_pready,
  input logic [NREQ-1:0] req_pready
);
  AST_EVAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    eval_phase |-> (!cmp_psel && !cmp_penable)); // R9

  AST_ENABLE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    cmp_penable |-> (cmp_psel && $past(cmp_psel))); // R4

  AST_SEL_FROM_DECISION: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_psel) |-> $past(eval_phase)); // R4

  AST_SINGLE_READY: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_pready)); // R6

  AST_READY_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (|req_pready) |-> (cmp_penable && cmp_pready)); // R6

  AST_DONE_TO_EVAL: assert property (@(posedge clk) disable iff (rst)
    (cmp_penable && cmp_pready) |=> eval_phase); // R8
endmodule

bind apb_prio_xbar apbx_checker #(.NREQ(NREQ)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .eval_phase  (eval_phase),
  .cmp_psel    (cmp_psel),
  .cmp_penable (cmp_penable),
  .cmp_pready  (cmp_pready),
  .req_pready  (req_pready)
);

// File: tb/sim_apb_prio_xbar.sv
module sim_apb_prio_xbar;
  localparam int N  = 32;
  localparam int AW = 32;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_psel = '0, req_penable = '0, req_pwrite = '0;
  logic [N*AW-1:0] req_paddr = '0;
  logic [N*DW-1:0] req_pwdata = '0;
  logic [N-1:0]    req_pready;
  logic [N*DW-1:0] req_prdata;
  logic            cmp_psel, cmp_penable, cmp_pwrite, eval_phase;
  logic [AW-1:0]   cmp_paddr;
  logic [DW-1:0]   cmp_pwdata;
  logic            cmp_pready = 1'b0;
  logic [DW-1:0]   cmp_prdata = '0;

  apb_prio_xbar #(.NREQ(N), .AW(AW), .DW(DW)) u0 (.*);

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // requester models
  logic          act [N];
  logic [N-1:0]  seen_rdy = '0;
  // reference model of the grant
  int            m_st = 0;   // 0 eval, 1 setup, 2 access
  int            m_g  = 0;
  int            done_cnt = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = i;
    if (v == '0) lowest = -1;
  endfunction

  task automatic cycle(input logic [N-1:0] force_start, input int pct, input bit rdy_always);
    logic [N-1:0] exp_rdy;
    bit           dmis;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (act[i] && seen_rdy[i]) act[i] = 1'b0;
      if (act[i]) begin
        req_penable[i] = 1'b1;
      end else if (force_start[i] || (pct > 0 && int'($urandom % 100) < pct)) begin
        act[i] = 1'b1;
        req_psel[i] = 1'b1;
        req_penable[i] = 1'b0;
        req_pwrite[i] = 1'($urandom);
        req_paddr[i*AW +: AW] = $urandom;
        req_pwdata[i*DW +: DW] = $urandom;
      end else begin
        req_psel[i] = 1'b0;
        req_penable[i] = 1'b0;
      end
    end
    cmp_pready = rdy_always ? 1'b1 : 1'($urandom);
    cmp_prdata = $urandom;
    #1;
    chk("R3 eval_phase", 64'(eval_phase), 64'(m_st == 0));
    if (m_st == 0) begin
      chk("R9 idle psel", 64'(cmp_psel), 64'd0);
      chk("R9 idle penable", 64'(cmp_penable), 64'd0);
    end else begin
      chk("R4 psel follows winner", 64'(cmp_psel), 64'(req_psel[m_g]));
      chk("R4 penable by phase", 64'(cmp_penable), (m_st == 2) ? 64'(req_penable[m_g]) : 64'd0);
      chk("R5 pwrite", 64'(cmp_pwrite), 64'(req_pwrite[m_g]));
      chk("R5 paddr", 64'(cmp_paddr), 64'(req_paddr[m_g*AW +: AW]));
      chk("R5 pwdata", 64'(cmp_pwdata), 64'(req_pwdata[m_g*DW +: DW]));
    end
    exp_rdy = '0;
    if (m_st == 2) exp_rdy[m_g] = cmp_pready;
    chk("R6 R10 ready routing", 64'(req_pready), 64'(exp_rdy));
    dmis = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_prdata[i*DW +: DW] !== ((m_st == 2 && i == m_g) ? cmp_prdata : '0)) dmis = 1'b1;
    end
    chk("R6 prdata routing", 64'(dmis), 64'd0);
    // advance the model as the coming edge will
    case (m_st)
      0: if (req_psel != '0) begin m_g = lowest(req_psel); m_st = 1; end
      1: m_st = 2;
      default: if (cmp_pready) begin m_st = 0; done_cnt++; end
    endcase
    seen_rdy = req_pready;
  endtask

  initial begin
    for (int i = 0; i < N; i++) act[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset eval", 64'(eval_phase), 64'd1);
    chk("R1 reset psel", 64'(cmp_psel), 64'd0);
    chk("R1 reset penable", 64'(cmp_penable), 64'd0);
    chk("R1 reset ready", 64'(req_pready), 64'd0);
    rst = 1'b0;
    // idle: no requests keep the block evaluating (R3, R9)
    repeat (4) cycle('0, 0, 1'b0);
    // contention among 31, 5 and 2 with ready held high, including setup (R2, R7, R10)
    cycle((32'b1 << 31) | (32'b1 << 5) | (32'b1 << 2), 0, 1'b1);
    chk("R2 winner is 2", 64'(m_g), 64'd2);
    cycle('0, 0, 1'b1);
    chk("R2 completer addr from 2", 64'(cmp_paddr), 64'(req_paddr[2*AW +: AW]));
    // requester 0 arrives while 2 is held: grant must not move (R7)
    cycle(32'b1, 0, 1'b1);
    repeat (16) cycle('0, 0, 1'b1);
    chk("R8 all four served", 64'(done_cnt), 64'd4);
    // random traffic, light then heavy, random completer wait states
    repeat (3000) cycle('0, 8, 1'b0);
    repeat (3000) cycle('0, 60, 1'b0);
    repeat (200) cycle('0, 0, 1'b1);
    chk("R8 drained", 64'(eval_phase), 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule